// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is a hardware master for the two-wire station-management bus used to reach Ethernet PHY registers. From a system clock it produces the management clock (MDC). It drives the bidirectional data line through three separate signals: an output value, an output enable and an input. Each transaction is a single 64-slot frame. The frame carries 32 preamble ones, the start pattern, an opcode, a 5-bit PHY address and a 5-bit register address. A turnaround and 16 data bits follow.

A client raises `start` for one cycle with the direction flag, both addresses and, for a write, the data word. `busy` stays high while the frame is on the wire. `done` pulses once at the end of the frame. After a read, `rdata` holds the captured word. On reads the master releases the data line at the turnaround so the PHY can drive it. On every transaction it releases the line at the end of the frame. Only one transaction is in flight at a time.

The MDC half-period is `HALF_DIV` system clocks. The minimum is 3. The default of 40 keeps MDC at 2.5 MHz or below for system clocks up to 200 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `mdc`, `mdio_oe`, `mdio_o`, `busy` and `done` are 0. `rdata` resets to 0.
- R2: Frame slots are numbered 0 to 63. In slots 0 to 31 the master drives a 1 with `mdio_oe` high.
- R3: Slots 32 and 33 carry 0 then 1. Slots 34 and 35 carry the opcode: 1,0 for a read (`rd`=1) and 0,1 for a write (`rd`=0).
- R4: Slots 36 to 40 carry `phy_addr`, and slots 41 to 45 carry `reg_addr`, each sent MSB first.
- R5: On a write, `mdio_oe` stays high for all 64 slots. Slots 46 and 47 carry 1 then 0, and slots 48 to 63 carry `wdata` bit 15 down to bit 0.
- R6: On a read, `mdio_oe` is low from slot 46 through slot 63. The value on `mdio_i` during slot 48+k becomes `rdata` bit 15-k.
- R7: Each slot lasts `HALF_DIV` cycles with `mdc` low, then `HALF_DIV` cycles with `mdc` high. `mdio_o` changes only at a slot boundary, while `mdc` is low.
- R8: Suppose `start` is sampled at a clock edge while idle. `busy` is then high for the next 128·`HALF_DIV` cycles. After that, `done` is high for exactly one cycle with `busy`, `mdc` and `mdio_oe` low.
- R9: A `start` raised while `busy` is high is ignored. The running frame and its result are unaffected.
- R10: `rdata` changes only in the cycle where `done` rises after a read. It is held from then until the next read completes. Writes leave it unchanged.
- R11: `mdio_i` passes through a two-flop synchronizer. It is sampled on the last system clock of each high phase. The value is therefore taken from `mdio_i` as it stood at least one cycle after the MDC rising edge.
- R12: A new `start` may be accepted in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rd | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data captured by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with `HALF_DIV` = 3, the smallest legal value. This makes a frame 384 cycles long, so a run can hold several writes, reads, an ignored mid-frame request and a back-to-back start. In the bench, the PHY changes `mdio_i` just after each MDC rising edge. At this divider a synchronizer one stage too deep, or a sample point one cycle early, picks up the previous bit, and the read data comes back shifted. The reference model checks every output on every clock, so an off-by-one in the phase lengths, the slot count or the release point of `mdio_oe` also shows up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_SLOTS = 64;
  localparam int unsigned SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned TA_SLOT     = 46;
  localparam int unsigned DATA_SLOT   = TA_SLOT + 2;
  localparam int unsigned LAST_SLOT   = FRAME_SLOTS - 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mst_state_e;

  // Full outgoing bit pattern, slot 0 in the MSB.
  function automatic logic [FRAME_SLOTS-1:0] build_frame(
    input logic              is_read,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0] op;
    op = is_read ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic end_high
);
  localparam int unsigned CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  if (HALF_DIV < 3) begin : g_bad_div
    $error("HALF_DIV must be at least 3");
  end

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             at_last;

  assign at_last = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (at_last) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign end_high = run & mdc_q & at_last;
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b1;
        else        pipe_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= 1'b1;
        else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              end_high,
  input  logic              din,
  output logic              run,
  output logic              line_o,
  output logic              line_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [SLOT_W-1:0] SLOT_TA   = SLOT_W'(TA_SLOT);
  localparam logic [SLOT_W-1:0] SLOT_DATA = SLOT_W'(DATA_SLOT);
  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(LAST_SLOT);

  mst_state_e             state_q, state_d;
  logic [SLOT_W-1:0]      slot_q, slot_d;
  logic [FRAME_SLOTS-1:0] sh_q, sh_d;
  logic                   rd_q, rd_d;
  logic [DATA_W-1:0]      cap_q, cap_d;
  logic [DATA_W-1:0]      rdata_q, rdata_d;
  logic                   done_q, done_d;
  logic [DATA_W-1:0]      cap_next;

  assign cap_next = {cap_q[DATA_W-2:0], din};

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    cap_d   = cap_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          slot_d  = '0;
          rd_d    = rd;
          cap_d   = '0;
          sh_d    = build_frame(rd, phy_addr, reg_addr, rd ? '0 : wdata);
        end
      end
      ST_RUN: begin
        if (end_high) begin
          if (rd_q && (slot_q >= SLOT_DATA)) cap_d = cap_next;
          if (slot_q == SLOT_END) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            if (rd_q) rdata_d = cap_next;
          end else begin
            slot_d = slot_q + 1'b1;
            sh_d   = {sh_q[FRAME_SLOTS-2:0], 1'b0};
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      cap_q   <= cap_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  assign run     = (state_q == ST_RUN);
  assign line_oe = run && !(rd_q && (slot_q >= SLOT_TA));
  assign line_o  = line_oe & sh_q[FRAME_SLOTS-1];
  assign done    = done_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic run;
  logic end_high;
  logic din_sync;

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mdc      (mdc),
    .end_high (end_high)
  );

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mdio_i),
    .dout  (din_sync)
  );

  mdio_frame_ctl u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd       (rd),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .end_high (end_high),
    .din      (din_sync),
    .run      (run),
    .line_o   (mdio_o),
    .line_oe  (mdio_oe),
    .done     (done),
    .rdata    (rdata)
  );

  assign busy = run;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rdata,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r1_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  a_r1_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);
  a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
  a_r6_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |=> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rdata   (rdata),
  .busy    (busy),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int H  = 3;
  localparam int FR = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, rd;
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wdata, rdata;
  logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd(rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model
  bit          m_act, m_rd, m_done, cmp_en;
  int          n;
  logic [4:0]  m_phy, m_reg;
  logic [15:0] m_wd, m_val, m_rdata, phy_val;

  function automatic bit frame_bit(int s);
    if (s < 32)  return 1'b1;
    if (s == 32) return 1'b0;
    if (s == 33) return 1'b1;
    if (s == 34) return m_rd;
    if (s == 35) return !m_rd;
    if (s < 41)  return m_phy[40 - s];
    if (s < 46)  return m_reg[45 - s];
    if (s == 46) return 1'b1;
    if (s == 47) return 1'b0;
    return m_wd[63 - s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; n = 0; m_rdata = '0; m_rd = 0;
      m_phy = '0; m_reg = '0; m_wd = '0; m_val = '0;
    end else begin
      m_done = 0;
      if (m_act) begin
        n++;
        if (n == FR) begin
          m_act = 0; m_done = 1;
          if (m_rd) m_rdata = m_val;
        end
      end else if (start) begin
        m_act = 1; n = 0; m_rd = rd; m_phy = phy_addr; m_reg = reg_addr;
        m_wd = rd ? 16'h0 : wdata; m_val = phy_val;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int  slot;
      bit  e_mdc, e_oe, e_o;
      string t;
      slot  = n / (2 * H);
      e_mdc = m_act && ((n % (2 * H)) >= H);
      e_oe  = m_act && !(m_rd && slot >= 46);
      e_o   = e_oe ? frame_bit(slot) : 1'b0;
      t = (slot < 32) ? "R2" : (slot < 36) ? "R3" : (slot < 46) ? "R4" : (m_rd ? "R6" : "R5");
      chk("R7", "mdc", mdc, e_mdc);
      chk(m_rd ? "R6" : "R5", "mdio_oe", mdio_oe, e_oe);
      chk(t, "mdio_o", mdio_o, e_o);
      chk("R8", "busy", busy, m_act);
      chk("R8", "done", done, m_done);
      chk("R10", "rdata", rdata, m_rdata);
    end
    // PHY model: a new bit appears just after each MDC rising edge (R11)
    begin
      int ps;
      ps = (n / (2 * H)) - (((n % (2 * H)) >= H) ? 0 : 1);
      if (m_act && m_rd && ps >= 48 && ps <= 63) mdio_i <= m_val[63 - ps];
      else                                         mdio_i <= 1'b1;
    end
  end

  task automatic issue(input bit r, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] val);
    phy_val  = val;
    rd       = r;
    phy_addr = pa;
    reg_addr = ra;
    wdata    = wd;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < FR + 10; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; rd = 0; phy_addr = '0; reg_addr = '0; wdata = '0;
    phy_val = '0; mdio_i = 1'b1; cmp_en = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mdc in reset", mdc, 0);
    chk("R1", "oe in reset", mdio_oe, 0);
    chk("R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "mdc idle", mdc, 0);
    chk("R1", "mdio_o idle", mdio_o, 0);
    chk("R1", "done idle", done, 0);
    chk("R1", "rdata reset", rdata, 0);
    cmp_en = 1;

    // write with mixed pattern (R2-R5, R7, R8)
    issue(0, 5'h1A, 5'h05, 16'hA53C, 16'h0);
    wait_done();
    @(negedge clk);
    chk("R10", "write leaves rdata", rdata, 16'h0);

    // read (R6, R11)
    issue(1, 5'h11, 5'h1F, 16'hFFFF, 16'h8001);
    wait_done();
    chk("R6", "read word", rdata, 16'h8001);
    @(negedge clk);

    // read with a request inside the frame (R9)
    issue(1, 5'h03, 5'h10, 16'h0, 16'h7FFE);
    repeat (100) @(negedge clk);
    issue(0, 5'h1F, 5'h1F, 16'h1234, 16'h5555);
    wait_done();
    chk("R9", "ignored request leaves result", rdata, 16'h7FFE);

    // back-to-back: start on the done cycle (R12)
    issue(0, 5'h00, 5'h00, 16'h0000, 16'h0);
    wait_done();
    chk("R12", "done seen", done, 1);
    issue(1, 5'h15, 5'h0A, 16'h0, 16'hC3A5);
    chk("R12", "busy after chained start", busy, 1);
    wait_done();
    chk("R6", "chained read word", rdata, 16'hC3A5);
    @(negedge clk);

    // write after read keeps rdata (R10)
    issue(0, 5'h0F, 5'h1E, 16'hFFFF, 16'h0);
    wait_done();
    repeat (3) @(negedge clk);
    chk("R10", "rdata held after write", rdata, 16'hC3A5);
    chk("R1", "idle oe", mdio_oe, 0);
    chk("R1", "idle mdc", mdc, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule